// File: doc/BRIEF.md
# Dual-Engine Instruction Memory Loader

This block owns the instruction memories of two small programmable engines and loads them from a 32-bit register-write bus. Each engine has its own pair of ports: a pointer port that picks an instruction slot, and a data port that builds a 64-bit instruction out of two consecutive 32-bit writes. The low half comes first and the high half second. The second write commits the word and moves the pointer on by one slot. Software sends the same code image through both pairs, because each engine keeps a private memory.

A control write carries a 2-bit mode and a start instruction pointer. One control register drives both engines at once. A second control register drives engine 0 only. Mode 00 suspends an engine. A suspended engine drains for a fixed number of cycles before it reports idle. Mode 11 starts an engine at the supplied pointer. A fetch-mode register selects direct loading (value 0) or engine self-fetch. In self-fetch mode the data ports ignore every write. A load attempt while an engine is not idle is dropped and sets a sticky error flag for that engine. The engines themselves are stand-in stubs that only track idle, running and draining. Each engine's fetch side reads its memory through a registered read port.

Top module: `dual_ucode_loader`

## Requirements
- R1: After reset both engines are idle and not running, both error flags are 0, both start pointers are 0, and the fetch mode is direct (0).
- R2: Two accepted writes to an engine's data port (register 4 for engine 0, 6 for engine 1) store {second write, first write} at the current pointer. The fetch port returns that word one clock after the fetch address is presented.
- R3: The pointer advances by one only after the second write of a pair. It wraps from DEPTH-1 to 0.
- R4: A write to an engine's pointer port (register 3 for engine 0, 5 for engine 1) loads the pointer from bits [AW-1:0]. It also discards any pending half, so the next data write is taken as a low half.
- R5: Writes to one engine's ports never change the other engine's memory.
- R6: A write to register 0 with mode bits [1:0] = 11 starts both engines. From the next clock they run, idle is low, and each start pointer equals bits [AW+2:3] of the write.
- R7: A write to register 1 acts on engine 0 alone. Engine 1's run state and start pointer are unchanged.
- R8: A control write with mode 00 stops a running engine at once. Idle rises exactly DRAIN clocks after the write edge.
- R9: A control write with mode 01 or 10 has no effect.
- R10: A data-port write in direct mode while the engine is not idle leaves memory and pointer unchanged. It sets that engine's error flag, which stays set until reset.
- R11: While the fetch mode (register 2, bits [1:0]) is nonzero, data-port writes are ignored and no error flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Register write strobe |
| bus_reg | input | 3 | Register select |
| bus_wdata | input | 32 | Write data |
| fetch_addr0 | input | AW | Engine 0 instruction read address |
| fetch_addr1 | input | AW | Engine 1 instruction read address |
| fetch_data0 | output | 64 | Engine 0 instruction, one clock after address |
| fetch_data1 | output | 64 | Engine 1 instruction, one clock after address |
| eng_idle | output | 2 | Per-engine idle status |
| eng_run | output | 2 | Per-engine running status |
| load_err | output | 2 | Per-engine sticky load error |
| start_ip0 | output | AW | Engine 0 start instruction pointer |
| start_ip1 | output | AW | Engine 1 start instruction pointer |

## Verification
A register write takes effect on the clock edge where it is strobed. Status, pointers and error flags are therefore sampled at the falling edge right after that write. A memory word is readable through the fetch port one edge after the address is presented. A scoreboard records each fetch together with the cycle its result is due, and the monitor compares the result only when that cycle is reached. For the drain rule, the bench counts falling edges after the suspend write. It confirms that idle is still low at DRAIN-1 and high at DRAIN.

// File: rtl/ucl_pkg.sv
package ucl_pkg;
  typedef enum logic [2:0] {
    REG_CTRL_ALL = 3'd0,
    REG_CTRL_E0  = 3'd1,
    REG_FETCH    = 3'd2,
    REG_PTR_E0   = 3'd3,
    REG_DAT_E0   = 3'd4,
    REG_PTR_E1   = 3'd5,
    REG_DAT_E1   = 3'd6
  } reg_sel_e;

  typedef enum logic [1:0] {
    ENG_IDLE  = 2'd0,
    ENG_RUN   = 2'd1,
    ENG_DRAIN = 2'd2
  } eng_state_e;

  localparam logic [1:0] MODE_HALT = 2'b00;
  localparam logic [1:0] MODE_GO   = 2'b11;
  localparam int         IP_LSB    = 3;
endpackage

// File: rtl/ucode_bank.sv
module ucode_bank #(
  parameter int AW = 8,
  parameter int DW = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            ptr_we,
  input  logic [AW-1:0]   ptr_in,
  input  logic            dat_we,
  input  logic [DW-1:0]   dat_in,
  input  logic            direct,
  input  logic            load_ok,
  input  logic [AW-1:0]   rd_addr,
  output logic [2*DW-1:0] rd_data,
  output logic            err
);
  localparam int DEPTH = 1 << AW;

  logic [2*DW-1:0] mem [DEPTH];
  logic [AW-1:0]   wptr;
  logic            hi_phase;
  logic [DW-1:0]   lo_q;
  logic            accept;

  assign accept = dat_we && direct && load_ok;

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr     <= '0;
      hi_phase <= 1'b0;
      lo_q     <= '0;
      err      <= 1'b0;
    end else begin
      if (ptr_we) begin
        wptr     <= ptr_in;
        hi_phase <= 1'b0;
      end else if (accept) begin
        if (hi_phase) begin
          wptr     <= wptr + 1'b1;
          hi_phase <= 1'b0;
        end else begin
          lo_q     <= dat_in;
          hi_phase <= 1'b1;
        end
      end
      if (dat_we && direct && !load_ok) err <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (accept && hi_phase) mem[wptr] <= {dat_in, lo_q};
    rd_data <= mem[rd_addr];
  end

  AST_PTR_STEP: assert property (@(posedge clk) disable iff (rst)
    accept && hi_phase |=> wptr == $past(wptr) + 1'b1); // R3
  AST_PTR_HOLD_LOW: assert property (@(posedge clk) disable iff (rst)
    accept && !hi_phase |=> $stable(wptr)); // R3
  AST_PTR_LOAD: assert property (@(posedge clk) disable iff (rst)
    ptr_we |=> wptr == $past(ptr_in) && !hi_phase); // R4
  AST_BUSY_FLAGS: assert property (@(posedge clk) disable iff (rst)
    dat_we && direct && !load_ok |=> err && $stable(wptr)); // R10
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    err |=> err); // R10
  AST_SELF_FETCH_QUIET: assert property (@(posedge clk) disable iff (rst)
    dat_we && !direct && !ptr_we |=> $stable(wptr) && $stable(err)); // R11
endmodule

// File: rtl/engine_stub.sv
module engine_stub
  import ucl_pkg::*;
#(
  parameter int AW    = 8,
  parameter int DRAIN = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ctl_we,
  input  logic [1:0]    ctl_mode,
  input  logic [AW-1:0] ctl_ip,
  output logic          idle,
  output logic          run,
  output logic [AW-1:0] ip
);
  localparam int CW = $clog2(DRAIN + 1);

  eng_state_e    state;
  logic [CW-1:0] cnt;
  logic          go, halt;

  assign go   = ctl_we && (ctl_mode == MODE_GO);
  assign halt = ctl_we && (ctl_mode == MODE_HALT);

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ENG_IDLE;
      cnt   <= '0;
      ip    <= '0;
    end else if (go) begin
      state <= ENG_RUN;
      ip    <= ctl_ip;
    end else if (halt && state == ENG_RUN) begin
      state <= ENG_DRAIN;
      cnt   <= CW'(DRAIN - 1);
    end else if (state == ENG_DRAIN) begin
      if (cnt == '0) state <= ENG_IDLE;
      else           cnt   <= cnt - 1'b1;
    end
  end

  assign idle = (state == ENG_IDLE);
  assign run  = (state == ENG_RUN);

  AST_GO_RUNS: assert property (@(posedge clk) disable iff (rst)
    go |=> run && !idle && ip == $past(ctl_ip)); // R6
  AST_HALT_STOPS: assert property (@(posedge clk) disable iff (rst)
    halt |=> !run); // R8
  AST_DRAIN_BUSY: assert property (@(posedge clk) disable iff (rst)
    halt && run |=> !idle); // R8
  AST_ODD_MODE_INERT: assert property (@(posedge clk) disable iff (rst)
    ctl_we && ctl_mode != MODE_GO && ctl_mode != MODE_HALT && run |=> run && $stable(ip)); // R9
endmodule

// File: rtl/dual_ucode_loader.sv
module dual_ucode_loader
  import ucl_pkg::*;
#(
  parameter int AW    = 8,
  parameter int DRAIN = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bus_we,
  input  logic [2:0]    bus_reg,
  input  logic [31:0]   bus_wdata,
  input  logic [AW-1:0] fetch_addr0,
  input  logic [AW-1:0] fetch_addr1,
  output logic [63:0]   fetch_data0,
  output logic [63:0]   fetch_data1,
  output logic [1:0]    eng_idle,
  output logic [1:0]    eng_run,
  output logic [1:0]    load_err,
  output logic [AW-1:0] start_ip0,
  output logic [AW-1:0] start_ip1
);
  localparam int NENG = 2;

  logic [1:0]    fetch_mode;
  logic          direct;
  logic [AW-1:0] fa  [NENG];
  logic [63:0]   fd  [NENG];
  logic [AW-1:0] ipv [NENG];

  always_ff @(posedge clk) begin
    if (rst)                              fetch_mode <= 2'b00;
    else if (bus_we && bus_reg == REG_FETCH) fetch_mode <= bus_wdata[1:0];
  end
  assign direct = (fetch_mode == 2'b00);

  assign fa[0] = fetch_addr0;
  assign fa[1] = fetch_addr1;

  for (genvar g = 0; g < NENG; g++) begin : g_eng
    localparam logic [2:0] PTR_SEL = 3'(REG_PTR_E0 + 2 * g);
    localparam logic [2:0] DAT_SEL = 3'(REG_DAT_E0 + 2 * g);
    logic ctl_hit;

    assign ctl_hit = bus_we && (bus_reg == REG_CTRL_ALL || (g == 0 && bus_reg == REG_CTRL_E0));

    engine_stub #(.AW(AW), .DRAIN(DRAIN)) u_eng (
      .clk(clk), .rst(rst),
      .ctl_we(ctl_hit), .ctl_mode(bus_wdata[1:0]), .ctl_ip(bus_wdata[IP_LSB +: AW]),
      .idle(eng_idle[g]), .run(eng_run[g]), .ip(ipv[g])
    );

    ucode_bank #(.AW(AW), .DW(32)) u_bank (
      .clk(clk), .rst(rst),
      .ptr_we(bus_we && bus_reg == PTR_SEL), .ptr_in(bus_wdata[AW-1:0]),
      .dat_we(bus_we && bus_reg == DAT_SEL), .dat_in(bus_wdata),
      .direct(direct), .load_ok(eng_idle[g]),
      .rd_addr(fa[g]), .rd_data(fd[g]), .err(load_err[g])
    );
  end

  assign fetch_data0 = fd[0];
  assign fetch_data1 = fd[1];
  assign start_ip0   = ipv[0];
  assign start_ip1   = ipv[1];

  AST_E1_SPARED: assert property (@(posedge clk) disable iff (rst)
    bus_we && bus_reg == REG_CTRL_E0 |=> $stable(eng_run[1]) && $stable(start_ip1)); // R7
  AST_BOTH_START: assert property (@(posedge clk) disable iff (rst)
    bus_we && bus_reg == REG_CTRL_ALL && bus_wdata[1:0] == MODE_GO |=> eng_run == 2'b11); // R6
endmodule

// File: tb/sim_dual_ucode_loader.sv
module sim_dual_ucode_loader;
  import ucl_pkg::*;
  localparam int AW    = 8;
  localparam int DRAIN = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          bus_we = 1'b0;
  logic [2:0]    bus_reg = '0;
  logic [31:0]   bus_wdata = '0;
  logic [AW-1:0] fetch_addr0 = '0, fetch_addr1 = '0;
  logic [63:0]   fetch_data0, fetch_data1;
  logic [1:0]    eng_idle, eng_run, load_err;
  logic [AW-1:0] start_ip0, start_ip1;

  dual_ucode_loader #(.AW(AW), .DRAIN(DRAIN)) u0 (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_reg(bus_reg), .bus_wdata(bus_wdata),
    .fetch_addr0(fetch_addr0), .fetch_addr1(fetch_addr1),
    .fetch_data0(fetch_data0), .fetch_data1(fetch_data1),
    .eng_idle(eng_idle), .eng_run(eng_run), .load_err(load_err),
    .start_ip0(start_ip0), .start_ip1(start_ip1)
  );

  always #10 clk = ~clk;

  typedef struct {
    int          eng;
    logic [63:0] val;
    string       tag;
    int          due;
  } exp_t;

  exp_t exp_q[$];
  int   cyc = 0;
  int   vectors = 0;
  int   miss = 0;
  bit   done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      miss++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (exp_q.size() > 0 && cyc >= exp_q[0].due) begin
      exp_t it;
      it = exp_q.pop_front();
      chk(it.tag, (it.eng == 0) ? fetch_data0 : fetch_data1, it.val);
    end
  end

  task automatic wr(reg_sel_e r, logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_reg = r; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic load(int eng, logic [63:0] w);
    wr(eng == 0 ? REG_DAT_E0 : REG_DAT_E1, w[31:0]);
    wr(eng == 0 ? REG_DAT_E0 : REG_DAT_E1, w[63:32]);
  endtask

  task automatic rd(int eng, logic [AW-1:0] a, logic [63:0] v, string tag);
    exp_t it;
    @(negedge clk);
    if (eng == 0) fetch_addr0 = a; else fetch_addr1 = a;
    it.eng = eng; it.val = v; it.tag = tag; it.due = cyc + 1;
    exp_q.push_back(it);
    @(negedge clk);
  endtask

  function automatic logic [31:0] ctl(logic [AW-1:0] ip, logic [1:0] m);
    return (32'(ip) << 3) | 32'(m);
  endfunction

  localparam logic [63:0] WA = 64'hA1A2A3A4_05060708;
  localparam logic [63:0] WB = 64'hB1B2B3B4_15161718;
  localparam logic [63:0] WC = 64'hC1C2C3C4_25262728;
  localparam logic [63:0] WP = 64'hD0D1D2D3_35363738;
  localparam logic [63:0] WD = 64'hE1E2E3E4_45464748;
  localparam logic [63:0] WE = 64'hF1F2F3F4_55565758;
  localparam logic [63:0] WH = 64'h12345678_9ABCDEF0;

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      miss++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miss);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 idle", 64'(eng_idle), 64'h3);
    chk("R1 run", 64'(eng_run), 64'h0);
    chk("R1 err", 64'(load_err), 64'h0);
    chk("R1 ip", {start_ip1, start_ip0}, '0);

    // R2 R3: engine 0 pair loads at pointer 5 and 6
    wr(REG_PTR_E0, 32'd5);
    load(0, WA);
    load(0, WB);
    rd(0, 8'd5, WA, "R2 e0 word at 5");
    rd(0, 8'd6, WB, "R3 e0 next slot 6");

    // R5: engine 1 slot 5 separate
    wr(REG_PTR_E1, 32'd5);
    load(1, WC);
    rd(1, 8'd5, WC, "R5 e1 word at 5");
    rd(0, 8'd5, WA, "R5 e0 word untouched");

    // R4: pointer write drops a pending low half
    wr(REG_PTR_E0, 32'd10);
    wr(REG_DAT_E0, 32'hDEADBEEF);
    wr(REG_PTR_E0, 32'd10);
    load(0, WP);
    rd(0, 8'd10, WP, "R4 phase cleared");

    // R3 wrap
    wr(REG_PTR_E1, 32'd255);
    load(1, WD);
    load(1, WE);
    rd(1, 8'd255, WD, "R3 top slot");
    rd(1, 8'd0, WE, "R3 wrap to 0");

    // R9: odd modes inert
    wr(REG_CTRL_ALL, ctl(8'h11, 2'b01));
    wr(REG_CTRL_ALL, ctl(8'h11, 2'b10));
    chk("R9 idle", 64'(eng_idle), 64'h3);
    chk("R9 run", 64'(eng_run), 64'h0);
    chk("R9 ip", {start_ip1, start_ip0}, '0);

    // R6: broadcast start
    wr(REG_CTRL_ALL, ctl(8'h23, 2'b11));
    chk("R6 run", 64'(eng_run), 64'h3);
    chk("R6 idle", 64'(eng_idle), 64'h0);
    chk("R6 ip0", 64'(start_ip0), 64'h23);
    chk("R6 ip1", 64'(start_ip1), 64'h23);

    // R10: load while running is dropped and flagged
    wr(REG_PTR_E0, 32'd5);
    load(0, WE);
    chk("R10 err", 64'(load_err), 64'h1);
    rd(0, 8'd5, WA, "R10 memory unchanged");

    // R8: suspend timing
    wr(REG_CTRL_ALL, ctl(8'h00, 2'b00));
    chk("R8 run low", 64'(eng_run), 64'h0);
    repeat (DRAIN - 1) @(negedge clk);
    chk("R8 not yet idle", 64'(eng_idle), 64'h0);
    @(negedge clk);
    chk("R8 idle after drain", 64'(eng_idle), 64'h3);
    chk("R10 err sticky", 64'(load_err), 64'h1);

    // R7: engine 0 only
    wr(REG_CTRL_E0, ctl(8'h40, 2'b11));
    chk("R7 run", 64'(eng_run), 64'h1);
    chk("R7 ip0", 64'(start_ip0), 64'h40);
    chk("R7 ip1", 64'(start_ip1), 64'h23);
    wr(REG_CTRL_E0, ctl(8'h00, 2'b00));
    repeat (DRAIN) @(negedge clk);
    chk("R7 idle again", 64'(eng_idle), 64'h3);

    // R11: self-fetch mode ignores data port
    wr(REG_PTR_E1, 32'd7);
    load(1, WH);
    wr(REG_FETCH, 32'd3);
    wr(REG_PTR_E1, 32'd7);
    load(1, WB);
    chk("R11 no err", 64'(load_err), 64'h1);
    wr(REG_FETCH, 32'd0);
    rd(1, 8'd7, WH, "R11 memory unchanged");

    repeat (3) @(negedge clk);
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miss);
    $finish;
  end
endmodule